// File: doc/BRIEF.md
# Reloading Interval Timer with Access Acknowledge

This block holds two countdown timers behind a small register port. The main timer is loaded by software with a start value. On each enabled tick it steps down by two. When it reaches zero or below it raises a level interrupt. That interrupt stays up until software touches the status register. Any status access, read or write, drops the interrupt and puts the start value back into the counter, so the same access acknowledges the interrupt and rearms the timer. The main timer counts only while one gate bit of a separate interrupt-enable mask register is set.

The second timer is a free-running periodic source. While its period register is nonzero, each tick takes five off its count. When the result falls below one, the count reloads from the period register and a one-cycle interrupt pulse is issued. Ticks come from an external prescaler that is not part of this block.

The main timer is a three-state machine. IVT_IDLE means not armed: the start value is zero or negative, or the counter holds a non-positive value that was written into it. IVT_RUN means armed and counting. IVT_EXPIRED means it has reached the floor. The transitions are:
- load: a reload-register write goes to IVT_RUN when the value is positive, otherwise to IVT_IDLE.
- ack: a status access goes to IVT_RUN when the start value is positive, otherwise to IVT_IDLE.
- step: an enabled tick in IVT_RUN stays in IVT_RUN while the result is positive.
- expire: the same tick moves to IVT_EXPIRED when the result is zero or below, and it sets the interrupt.

All other cases hold the state.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, both interrupt outputs are 0 and every register (reload at address 0, status at 1, enable mask at 2, period at 3) reads back 0.
- R2: A write to address 0 stores the start value and also loads the running counter with it. A read of address 0 returns the start value. Read data appears on bus_rdata in the cycle after the read request and holds until the next read.
- R3: On a tick, the counter drops by exactly 2 only when all three conditions hold: the start value is nonzero, the counter is positive, and bit 1 of the enable mask is 1. Otherwise the tick leaves the counter unchanged.
- R4: The tick that brings the counter to zero or below sets irq_interval in the following cycle. irq_interval stays at 1 and the counter stays at that value through further ticks until an acknowledge.
- R5: A read of address 1 returns the counter value from before the access. It clears irq_interval, and afterwards the counter equals the start value.
- R6: A write to address 1 clears irq_interval and leaves the counter equal to the start value, whatever data was written.
- R7: When a status access and an expiring tick fall in the same cycle, the access wins. irq_interval stays 0 and the counter equals the start value.
- R8: The enable mask at address 2 is a full 32-bit read/write register. Bits other than bit 1 do not gate counting.
- R9: While the period register at address 3 is nonzero, each tick subtracts 5 from the periodic count. When the result is below 1, the count reloads from the period register and irq_periodic is 1 for exactly the one cycle after that tick. With a period of 0 there are no pulses.
- R10: Addresses 4 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| tick | input | 1 | Count enable pulse from the prescaler |
| irq_interval | output | 1 | Main timer interrupt, level, held until acknowledged |
| irq_periodic | output | 1 | Periodic timer interrupt, one-cycle pulse |

## Verification
The collision to watch is a status access arriving in the same clock as the tick that would expire the main timer. The bench arms the timer with a start value of 2 and then drives a status read and a tick together on one edge. The read must return 2, irq_interval must stay 0, and a later status read must again return 2. A design that lets the tick win would show the interrupt set or a counter of 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        IVT_IDLE    = 2'd0,
        IVT_RUN     = 2'd1,
        IVT_EXPIRED = 2'd2
    } ivt_state_t;

    localparam int RA_RELOAD = 0;
    localparam int RA_STATUS = 1;
    localparam int RA_MASK   = 2;
    localparam int RA_PERIOD = 3;

endpackage

// File: rtl/tmr_regport.sv
module tmr_regport #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] start_val,
    input  logic [DATA_W-1:0] count_val,
    input  logic [DATA_W-1:0] period_val,
    output logic              wr_reload,
    output logic              wr_period,
    output logic              acc_status,
    output logic              cnt_gate,
    output logic [DATA_W-1:0] rdata
);
    import tmr_pkg::*;

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_sel;
    logic              hit_reload, hit_status, hit_mask, hit_period, mapped;

    assign hit_reload = (addr == ADDR_W'(RA_RELOAD));
    assign hit_status = (addr == ADDR_W'(RA_STATUS));
    assign hit_mask   = (addr == ADDR_W'(RA_MASK));
    assign hit_period = (addr == ADDR_W'(RA_PERIOD));
    assign mapped     = hit_reload | hit_status | hit_mask | hit_period;

    assign wr_reload  = req & we & hit_reload;
    assign wr_period  = req & we & hit_period;
    assign acc_status = req & hit_status;
    assign cnt_gate   = mask_q[GATE_BIT];

    always_comb begin
        rd_sel = '0;
        if (hit_reload)      rd_sel = start_val;
        else if (hit_status) rd_sel = count_val;
        else if (hit_mask)   rd_sel = mask_q;
        else if (hit_period) rd_sel = period_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            rdata  <= '0;
        end else begin
            if (req && we && hit_mask) mask_q <= wdata;
            if (req && !we)            rdata  <= rd_sel;
        end
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !mapped) |=> (rdata == '0));

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && hit_mask) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
    parameter int DATA_W = 32,
    parameter int STEP   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     cnt_gate,
    input  logic                     wr_reload,
    input  logic signed [DATA_W-1:0] reload_val,
    input  logic                     acc_status,
    output logic signed [DATA_W-1:0] start_q,
    output logic signed [DATA_W-1:0] count_q,
    output logic                     irq
);
    import tmr_pkg::*;

    localparam logic signed [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    ivt_state_t                st_q, st_d;
    logic signed [DATA_W-1:0]  stepped;
    logic                      do_step;
    logic                      expire;

    assign stepped = count_q - STEP_V;
    assign do_step = (st_q == IVT_RUN) && tick && cnt_gate && !wr_reload && !acc_status;
    assign expire  = do_step && (stepped <= 0);

    // next-state: load, ack, step, expire
    always_comb begin
        st_d = st_q;
        if (wr_reload) begin
            st_d = (reload_val > 0) ? IVT_RUN : IVT_IDLE;
        end else if (acc_status) begin
            st_d = (start_q > 0) ? IVT_RUN : IVT_IDLE;
        end else begin
            unique case (st_q)
                IVT_IDLE:    st_d = IVT_IDLE;
                IVT_RUN:     st_d = expire ? IVT_EXPIRED : IVT_RUN;
                IVT_EXPIRED: st_d = IVT_EXPIRED;
                default:     st_d = IVT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IVT_IDLE;
        else        st_q <= st_d;
    end

    // data path and interrupt output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr_reload) begin
                start_q <= reload_val;
                count_q <= reload_val;
            end else if (acc_status) begin
                count_q <= start_q;
            end else if (do_step) begin
                count_q <= stepped;
            end
            if (acc_status)  irq <= 1'b0;
            else if (expire) irq <= 1'b1;
        end
    end

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_gate && !wr_reload && !acc_status) |=> $stable(count_q));

    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_gate && start_q != 0 && count_q > 0 && !wr_reload && !acc_status)
        |=> (count_q == $past(count_q) - STEP_V));

    assert_irq_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !acc_status) |=> irq);

    assert_floor_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q <= 0 && !wr_reload && !acc_status) |=> $stable(count_q));

    assert_ack_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_status |=> (!irq && count_q == start_q));

endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic #(
    parameter int DATA_W = 32,
    parameter int STEP   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     wr_period,
    input  logic signed [DATA_W-1:0] period_wdata,
    output logic signed [DATA_W-1:0] period_q,
    output logic                     pulse
);
    localparam int EXT_W = DATA_W + 1;
    localparam logic signed [EXT_W-1:0] STEP_X = EXT_W'(STEP);

    logic signed [DATA_W-1:0] cur_q;
    logic signed [EXT_W-1:0]  diff;
    logic                     active;
    logic                     wrap;

    assign diff   = {cur_q[DATA_W-1], cur_q} - STEP_X;
    assign active = tick && (period_q != 0);
    assign wrap   = active && (diff < EXT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            cur_q    <= '0;
            pulse    <= 1'b0;
        end else begin
            if (wr_period) period_q <= period_wdata;
            if (wrap)        cur_q <= period_q;
            else if (active) cur_q <= diff[DATA_W-1:0];
            pulse <= wrap;
        end
    end

    assert_pulse_from_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));

    assert_zero_period_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == 0) |=> (!pulse && $stable(cur_q)));

endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int GATE_BIT = 1,
    parameter int IV_STEP  = 2,
    parameter int PER_STEP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq_interval,
    output logic              irq_periodic
);
    logic                     wr_reload, wr_period, acc_status, cnt_gate;
    logic signed [DATA_W-1:0] start_v, count_v, period_v;

    tmr_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_port (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .start_val(start_v), .count_val(count_v),
        .period_val(period_v), .wr_reload(wr_reload), .wr_period(wr_period),
        .acc_status(acc_status), .cnt_gate(cnt_gate), .rdata(bus_rdata)
    );

    tmr_interval #(.DATA_W(DATA_W), .STEP(IV_STEP)) u_ivt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_gate(cnt_gate),
        .wr_reload(wr_reload), .reload_val(bus_wdata), .acc_status(acc_status),
        .start_q(start_v), .count_q(count_v), .irq(irq_interval)
    );

    tmr_periodic #(.DATA_W(DATA_W), .STEP(PER_STEP)) u_per (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_period(wr_period),
        .period_wdata(bus_wdata), .period_q(period_v), .pulse(irq_periodic)
    );

endmodule

// File: tb/tb_tick_timer_pair.sv
module tb_tick_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, tick = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_interval, irq_periodic;
    int          n_run = 0, n_fail = 0;
    logic        finished = 1'b0;

    always #10 clk = ~clk;

    tick_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq_interval(irq_interval), .irq_periodic(irq_periodic)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; @(negedge clk); tick = 0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq_interval", {31'b0, irq_interval}, 0);
        check("R1 irq_periodic", {31'b0, irq_periodic}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R1 register zero", v, 0);
        end
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(0, 32'd40);
        rd(0, v); check("R2 reload readback", v, 32'd40);
        rd(1, v); check("R2 counter loaded", v, 32'd40);
        @(negedge clk);
        check("R2 rdata holds", bus_rdata, 32'd40);
    endtask

    task automatic t_gated();
        logic [31:0] v;
        wr(2, 32'hFFFF_FFFD);
        wr(0, 32'd3);
        ticks(5);
        check("R3 gate off no irq", {31'b0, irq_interval}, 0);
        rd(1, v); check("R8 other mask bits do not gate", v, 32'd3);
        wr(2, 32'd2);
        wr(0, 32'hFFFF_FFFC);
        ticks(4);
        check("R3 negative start no irq", {31'b0, irq_interval}, 0);
        rd(1, v); check("R3 negative counter unchanged", v, 32'hFFFF_FFFC);
    endtask

    task automatic t_expire_read_ack();
        logic [31:0] v;
        wr(2, 32'd2);
        wr(0, 32'd5);
        ticks(2);
        check("R4 not yet expired at 1", {31'b0, irq_interval}, 0);
        ticks(1);
        check("R4 irq on reaching -1", {31'b0, irq_interval}, 1);
        ticks(3);
        check("R4 irq held", {31'b0, irq_interval}, 1);
        rd(1, v);
        check("R5 read returns held counter", v, 32'hFFFF_FFFF);
        check("R5 read clears irq", {31'b0, irq_interval}, 0);
        rd(1, v); check("R5 counter back to start", v, 32'd5);
    endtask

    task automatic t_write_ack();
        logic [31:0] v;
        wr(0, 32'd1);
        ticks(1);
        check("R4 irq from start 1", {31'b0, irq_interval}, 1);
        wr(1, 32'h0000_0077);
        check("R6 write clears irq", {31'b0, irq_interval}, 0);
        rd(1, v); check("R6 counter equals start", v, 32'd1);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(0, 32'd2);
        bus_req = 1; bus_we = 0; bus_addr = 3'd1; tick = 1;
        @(negedge clk);
        bus_req = 0; tick = 0;
        check("R7 read value at collision", bus_rdata, 32'd2);
        check("R7 access wins, no irq", {31'b0, irq_interval}, 0);
        rd(1, v); check("R7 counter equals start", v, 32'd2);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(2, 32'hA5A5_5A5A);
        rd(2, v); check("R8 mask readback", v, 32'hA5A5_5A5A);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        int seen;
        wr(3, 32'd12);
        rd(3, v); check("R9 period readback", v, 32'd12);
        // count 0 -> wrap, then 7, 2, wrap
        tick = 1; @(negedge clk); tick = 0;
        check("R9 first tick wraps", {31'b0, irq_periodic}, 1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'b0, irq_periodic}, 0);
        seen = 0;
        for (int i = 0; i < 2; i++) begin
            tick = 1; @(negedge clk); tick = 0;
            seen += irq_periodic;
        end
        check("R9 no pulse at 7 and 2", 32'(seen), 0);
        tick = 1; @(negedge clk); tick = 0;
        check("R9 pulse on third tick", {31'b0, irq_periodic}, 1);
        wr(3, 32'd0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            tick = 1; @(negedge clk); tick = 0;
            seen += irq_periodic;
        end
        check("R9 zero period no pulse", 32'(seen), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(0, 32'd9);
        for (int a = 4; a < 8; a++) begin
            wr(3'(a), 32'hDEAD_BEEF);
            rd(3'(a), v); check("R10 unmapped reads zero", v, 0);
        end
        rd(0, v); check("R10 reload untouched", v, 32'd9);
        rd(2, v); check("R10 mask untouched", v, 32'hA5A5_5A5A);
        rd(3, v); check("R10 period untouched", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_reload();
        t_gated();
        t_expire_read_ack();
        t_write_ack();
        t_collision();
        t_mask();
        t_periodic();
        t_unmapped();
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(negedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule